// File: doc/BRIEF.md
# External Interrupt Trap Selector

This block sits next to a processor core and turns a set of level-sensitive interrupt lines into a single pending trap index for that core. Each of the sixteen lines stands for one interrupt level. Line 0 carries no meaning. Whenever the set of active lines changes, the block picks the highest active level. It writes that level into the index as an external-interrupt trap number and raises a hard interrupt request toward the core.

The core can also post a trap of its own kind into the same index. A pending trap outside the external-interrupt range is never overwritten by interrupt arbitration. When the core reports that it has taken the pending trap, the index is cleared and arbitration runs again in the same cycle, so any level that is still active is presented at once. A separate one-cycle wake pulse tells the core to leave a halted or sleeping state whenever a valid line newly goes active.

Top module: `ext_irq_selector`

## Requirements
- R1: After reset is released, `trap_idx_o` is 0, and `hard_req_o` and `wake_o` are 0.
- R2: The selected level is the highest set bit of `lvl_i` among bits 15 down to 1. Bit 0 is never selected. An active selection makes `trap_idx_o` equal to 0x10 OR the level, so bits 7:4 are 0x1 and bits 3:0 hold the level.
- R3: The block re-arbitrates every cycle against the current `lvl_i`. Raising a higher line or dropping the top line updates `trap_idx_o` on the next clock edge.
- R4: `hard_req_o` is set when a selection produces an index that differs from the index it replaces. It keeps its previous value when the index is unchanged. A selection equal to a freshly posted code therefore leaves it at 0.
- R5: While `trap_idx_o` holds a nonzero value whose bits 7:4 are not 0x1, changes on `lvl_i` leave both the index and `hard_req_o` unchanged.
- R6: When no line from 1 to 15 is active and the index holds an external interrupt (bits 7:4 equal 0x1), the index goes to 0 and `hard_req_o` goes to 0.
- R7: A `take_i` pulse clears the index and `hard_req_o`, then arbitration runs in the same cycle. If lines are still active, the next value is the new external index with `hard_req_o` = 1. If no lines are active, it is 0.
- R8: `wake_o` pulses for one cycle, one clock after any of lines 1 to 15 goes from 0 to 1. It stays 0 for bit 0 and for lines that are held high.
- R9: `trap_post_i` loads `trap_code_i` into the index (after any clear caused by `take_i` in the same cycle) and clears `hard_req_o`. A posted code whose bits 7:4 are 0x1 counts as an external interrupt and is re-arbitrated in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lvl_i | input | 16 | Interrupt level bitmap, bit i means level i is active |
| take_i | input | 1 | One-cycle pulse: the core has taken the pending trap |
| trap_post_i | input | 1 | One-cycle pulse: the core posts its own trap code |
| trap_code_i | input | 8 | Trap code loaded by `trap_post_i` |
| trap_idx_o | output | 8 | Pending trap index |
| hard_req_o | output | 1 | Hard interrupt request toward the core |
| wake_o | output | 1 | One-cycle pulse that clears the core's halted state |

## Verification
Every result is one register stage away from its cause. The index, the request and the wake pulse all change on the first rising edge after the inputs are applied, and arbitration after a take happens within that same edge. The bench drives inputs on the falling edge and checks on the following falling edge. Every check therefore sees exactly one update. A second check one cycle later confirms that the wake pulse has ended and that a held trap has not moved.

// File: rtl/ext_irq_sel_pkg.sv
package ext_irq_sel_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD     = 2'd0,
    ACT_SELECT   = 2'd1,
    ACT_WITHDRAW = 2'd2
  } sel_act_e;

endpackage

// File: rtl/irq_lvl_prio.sv
module irq_lvl_prio #(
  parameter int unsigned NUM_LVL = 16,
  localparam int unsigned LVL_W  = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] vec_i,
  output logic               any_o,
  output logic [LVL_W-1:0]   lvl_o
);

  localparam logic [NUM_LVL-1:0] VALID_MASK = ~NUM_LVL'(1);

  assign any_o = |(vec_i & VALID_MASK);

  // ascending scan, last hit wins -> highest level
  always_comb begin
    lvl_o = '0;
    for (int i = 1; i < int'(NUM_LVL); i++) begin
      if (vec_i[i]) lvl_o = LVL_W'(i);
    end
  end

  // R2
  always_comb begin
    if (any_o) begin
      top_level_chk: assert ((lvl_o != '0) && vec_i[lvl_o] && ((vec_i >> lvl_o) >> 1) == '0);
    end
  end

endmodule

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
  parameter int unsigned NUM_LVL = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL-1:0] lvl_i,
  output logic               wake_o
);

  localparam logic [NUM_LVL-1:0] VALID_MASK = ~NUM_LVL'(1);

  logic [NUM_LVL-1:0] lvl_q;
  logic               rise;

  assign rise = |(lvl_i & ~lvl_q & VALID_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      wake_o <= 1'b0;
    end else begin
      lvl_q  <= lvl_i;
      wake_o <= rise;
    end
  end

  // R8
  wake_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> wake_o);

  // R8
  no_wake_without_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> !wake_o);

endmodule

// File: rtl/irq_trap_idx.sv
module irq_trap_idx
  import ext_irq_sel_pkg::*;
#(
  parameter int unsigned     NUM_LVL  = 16,
  parameter int unsigned     IDX_W    = 8,
  parameter logic [IDX_W-1:0] EXT_BASE = 8'h10,
  localparam int unsigned    LVL_W    = $clog2(NUM_LVL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             post_i,
  input  logic [IDX_W-1:0] post_code_i,
  input  logic             any_i,
  input  logic [LVL_W-1:0] top_lvl_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             req_o
);

  logic [IDX_W-1:0] idx_q, idx_d, base, cand;
  logic             req_q, req_d, req_base;
  logic             base_ext, eligible;
  sel_act_e         act;

  function automatic logic is_ext(logic [IDX_W-1:0] v);
    return v[IDX_W-1:LVL_W] == EXT_BASE[IDX_W-1:LVL_W];
  endfunction

  // take clears first; a post in the same cycle then loads its code
  always_comb begin
    base     = take_i ? '0 : idx_q;
    if (post_i) base = post_code_i;
    req_base = (take_i || post_i) ? 1'b0 : req_q;
    base_ext = is_ext(base);
    eligible = (base == '0) || base_ext;
    cand     = EXT_BASE | IDX_W'(top_lvl_i);
  end

  always_comb begin
    act = ACT_HOLD;
    if (any_i && eligible)       act = ACT_SELECT;
    else if (!any_i && base_ext) act = ACT_WITHDRAW;
  end

  always_comb begin
    unique case (act)
      ACT_SELECT: begin
        idx_d = cand;
        req_d = (cand != base) ? 1'b1 : req_base;
      end
      ACT_WITHDRAW: begin
        idx_d = '0;
        req_d = 1'b0;
      end
      default: begin
        idx_d = base;
        req_d = req_base;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      req_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      req_q <= req_d;
    end
  end

  assign idx_o = idx_q;
  assign req_o = req_q;

  // R4
  req_has_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> (idx_q != '0));

  // R2
  ext_level_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ext(idx_q) |-> (idx_q[LVL_W-1:0] != '0));

  // R5
  foreign_trap_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !post_i && idx_q != '0 && !is_ext(idx_q)) |=> ($stable(idx_q) && $stable(req_q)));

  // R6
  empty_withdraw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !post_i && is_ext(idx_q) && !any_i) |=> (idx_q == '0 && !req_q));

  // R7
  take_rearb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !post_i && any_i) |=> (is_ext(idx_q) && req_q && idx_q[LVL_W-1:0] == $past(top_lvl_i)));

endmodule

// File: rtl/ext_irq_selector.sv
module ext_irq_selector #(
  parameter int unsigned      NUM_LVL  = 16,
  parameter int unsigned      IDX_W    = 8,
  parameter logic [IDX_W-1:0] EXT_BASE = 8'h10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL-1:0] lvl_i,
  input  logic               take_i,
  input  logic               trap_post_i,
  input  logic [IDX_W-1:0]   trap_code_i,
  output logic [IDX_W-1:0]   trap_idx_o,
  output logic               hard_req_o,
  output logic               wake_o
);

  localparam int unsigned LVL_W = $clog2(NUM_LVL);

  logic             any_lvl;
  logic [LVL_W-1:0] top_lvl;

  irq_lvl_prio #(
    .NUM_LVL (NUM_LVL)
  ) u_prio (
    .vec_i (lvl_i),
    .any_o (any_lvl),
    .lvl_o (top_lvl)
  );

  irq_rise_det #(
    .NUM_LVL (NUM_LVL)
  ) u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl_i),
    .wake_o (wake_o)
  );

  irq_trap_idx #(
    .NUM_LVL  (NUM_LVL),
    .IDX_W    (IDX_W),
    .EXT_BASE (EXT_BASE)
  ) u_idx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take_i),
    .post_i      (trap_post_i),
    .post_code_i (trap_code_i),
    .any_i       (any_lvl),
    .top_lvl_i   (top_lvl),
    .idx_o       (trap_idx_o),
    .req_o       (hard_req_o)
  );

endmodule

// File: tb/ext_irq_selector_tb_top.sv
`timescale 1ns/1ps
module ext_irq_selector_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] lvl_i = '0;
  logic        take_i = 1'b0;
  logic        trap_post_i = 1'b0;
  logic [7:0]  trap_code_i = '0;
  logic [7:0]  trap_idx_o;
  logic        hard_req_o;
  logic        wake_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ext_irq_selector dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lvl_i       (lvl_i),
    .take_i      (take_i),
    .trap_post_i (trap_post_i),
    .trap_code_i (trap_code_i),
    .trap_idx_o  (trap_idx_o),
    .hard_req_o  (hard_req_o),
    .wake_o      (wake_o)
  );

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic chk_all(string tag, logic [7:0] idx, logic req, logic wk);
    chk({tag, " idx"}, trap_idx_o, idx);
    chk({tag, " req"}, {7'd0, hard_req_o}, {7'd0, req});
    chk({tag, " wake"}, {7'd0, wake_o}, {7'd0, wk});
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    step(); step();
    rst_ni = 1'b1;
    step();
    chk_all("R1 reset", 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_priority();
    lvl_i = 16'h0001;
    step();
    chk_all("R2 R8 bit0 ignored", 8'h00, 1'b0, 1'b0);
    lvl_i = 16'h0091;
    step();
    chk_all("R2 R4 R8 top of 7,4", 8'h17, 1'b1, 1'b1);
    step();
    chk_all("R8 held no wake", 8'h17, 1'b1, 1'b0);
  endtask

  task automatic t_reeval();
    lvl_i = 16'h8091;
    step();
    chk_all("R3 raise 15", 8'h1F, 1'b1, 1'b1);
    lvl_i = 16'h0011;
    step();
    chk_all("R3 drop to 4", 8'h14, 1'b1, 1'b0);
    lvl_i = 16'h0000;
    step();
    chk_all("R6 empty withdraw", 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_take();
    lvl_i = 16'h0220;
    step();
    chk_all("R2 top of 9,5", 8'h19, 1'b1, 1'b1);
    take_i = 1'b1;
    lvl_i = 16'h0020;
    step();
    take_i = 1'b0;
    chk_all("R7 take rearb to 5", 8'h15, 1'b1, 1'b0);
    take_i = 1'b1;
    step();
    take_i = 1'b0;
    chk_all("R7 take same level", 8'h15, 1'b1, 1'b0);
    lvl_i = 16'h0000;
    step();
    chk_all("R6 clear", 8'h00, 1'b0, 1'b0);
    take_i = 1'b1;
    step();
    take_i = 1'b0;
    chk_all("R7 take empty", 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_foreign();
    lvl_i = 16'h0008;
    step();
    chk_all("R2 level 3", 8'h13, 1'b1, 1'b1);
    trap_post_i = 1'b1;
    trap_code_i = 8'h2A;
    step();
    trap_post_i = 1'b0;
    chk_all("R9 R5 post foreign", 8'h2A, 1'b0, 1'b0);
    lvl_i = 16'h8008;
    step();
    chk_all("R5 higher line ignored", 8'h2A, 1'b0, 1'b1);
    lvl_i = 16'h0000;
    step();
    chk_all("R5 empty ignored", 8'h2A, 1'b0, 1'b0);
    take_i = 1'b1;
    step();
    take_i = 1'b0;
    chk_all("R7 take foreign", 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_same_code();
    lvl_i = 16'h0008;
    step();
    chk_all("R4 level 3", 8'h13, 1'b1, 1'b1);
    trap_post_i = 1'b1;
    trap_code_i = 8'h13;
    step();
    trap_post_i = 1'b0;
    chk_all("R4 R9 equal code no req", 8'h13, 1'b0, 1'b0);
    lvl_i = 16'h0408;
    step();
    chk_all("R4 new index sets req", 8'h1A, 1'b1, 1'b1);
    lvl_i = 16'h0008;
    trap_post_i = 1'b1;
    trap_code_i = 8'h17;
    step();
    trap_post_i = 1'b0;
    chk_all("R9 ext code rearb", 8'h13, 1'b1, 1'b0);
    lvl_i = 16'h0000;
    step();
    chk_all("R6 final clear", 8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_priority();
    t_reeval();
    t_take();
    t_foreign();
    t_same_code();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule